// File: doc/BRIEF.md
# Pixel-Difference Hit Decoder

This block turns the digitized differences of a four-pixel group (pixels a, b, c, d) into a hit mask. In this readout the converter never sees a pixel alone. It sees the group imbalance (a+b)−(c+d) and the two pair differences a−b and c−d. A decision tree over the signs of these signed values locates the hit or hits.

Every difference is first placed into one of three classes: positive, negative or zero. A programmable threshold sets the band that counts as zero. The tree mode then steers on the group imbalance first and on a pair difference second. A second mode, the pair mode, treats the two pairs as independent. Each pair has one level input that is compared with the threshold to decide whether that pair holds a hit at all, and the pair's difference sign then names the hit pixel.

One group can be accepted on every clock. The mask is registered and appears one cycle after its input strobe.

Top module: `pdh_hit_decoder`

## Requirements
- R1: While reset is active, and after it is released until the first strobed input, out_valid is 0 and out_mask is 0000.
- R2: out_valid equals in_valid of the previous clock. The mask decoded from the inputs present with in_valid appears on out_mask in that same following cycle.
- R3: When in_valid is low, out_mask holds its previous value whatever the other inputs do.
- R4: Each signed value is classified against thresh. It is positive when greater than thresh, negative when less than −thresh, and zero when its magnitude is at most thresh. This holds at the extremes of the value range, including −2^(DATA_W−1) with the largest threshold.
- R5: out_mask bit 0 is pixel a, bit 1 is b, bit 2 is c and bit 3 is d. In tree mode with a positive group imbalance, only a or b may be set: a if a−b is positive, b if it is negative.
- R6: In tree mode with a negative group imbalance, only c or d may be set: c if c−d is positive, d if it is negative.
- R7: In tree mode with a zero group imbalance, the result is exactly one of {a,c}, {a,d}, {b,c}, {b,d} or none. A pair is reported only when both a−b and c−d are non-zero, each one picking its pixel by sign.
- R8: A pair whose difference classifies as zero contributes no hit in any mode, since equal signals on both coupled pixels cannot be resolved.
- R9: In pair mode each pair is decoded independently. Pixel a or b is reported only when a_level exceeds thresh, and pixel c or d only when c_level exceeds thresh. The pair difference sign picks the pixel, and the group imbalance has no effect.
- R10: pair_mode = 0 selects tree mode and pair_mode = 1 selects pair mode. For identical difference inputs the two modes give their own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe marking a group's values as present |
| pair_mode | input | 1 | 0: tree decode, 1: independent pair decode |
| sum_diff | input | DATA_W | Signed (a+b)−(c+d) |
| ab_diff | input | DATA_W | Signed a−b |
| cd_diff | input | DATA_W | Signed c−d |
| a_level | input | DATA_W | Signed level of a, used in pair mode |
| c_level | input | DATA_W | Signed level of c, used in pair mode |
| thresh | input | DATA_W-1 | Unsigned zero band half-width |
| out_valid | output | 1 | Registered strobe |
| out_mask | output | 4 | Registered hit mask {d,c,b,a} |

## Verification
The hardest case to reach is the exact edge of the zero band. A value equal to thresh or to −thresh must fall on the zero side, and one step further must not. At the most negative code the sign extension must keep the comparison against the largest threshold correct. Directed vectors set each difference to ±thresh and ±(thresh+1), use −128 with threshold 127, and hold a zero group imbalance while each pair side alone is zero. A random run keeps values within a few counts of a small threshold, so the band edges come up again with idle cycles in between.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_POS  = 2'b01,
    CLS_NEG  = 2'b10
  } cls_e;

  localparam int MASK_W  = 4;
  localparam int PAIR_W  = 2;
  localparam int NUM_CLS = 5;
  localparam int IDX_SUM = 0;
  localparam int IDX_AB  = 1;
  localparam int IDX_CD  = 2;
  localparam int IDX_AL  = 3;
  localparam int IDX_CL  = 4;
endpackage

// File: rtl/pdh_rst_sync.sv
module pdh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdh_classify.sv
module pdh_classify
  import pdh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-2:0] thresh,
  output cls_e              cls
);
  localparam int EXT_W = DATA_W + 1;

  logic signed [EXT_W-1:0] val_ext;
  logic signed [EXT_W-1:0] band_hi;
  logic signed [EXT_W-1:0] band_lo;

  always_comb begin
    val_ext = $signed({value[DATA_W-1], value});
    band_hi = $signed({2'b00, thresh});
    band_lo = -band_hi;
    if (val_ext > band_hi)      cls = CLS_POS;
    else if (val_ext < band_lo) cls = CLS_NEG;
    else                        cls = CLS_ZERO;
  end
endmodule

// File: rtl/pdh_pair_pick.sv
module pdh_pair_pick
  import pdh_pkg::*;
(
  input  cls_e              cls,
  output logic [PAIR_W-1:0] pick
);
  always_comb begin
    unique case (cls)
      CLS_POS: pick = 2'b01;
      CLS_NEG: pick = 2'b10;
      default: pick = 2'b00;
    endcase
  end
endmodule

// File: rtl/pdh_resolve.sv
module pdh_resolve
  import pdh_pkg::*;
(
  input  cls_e              cls_sum,
  input  cls_e              cls_ab,
  input  cls_e              cls_cd,
  input  cls_e              cls_al,
  input  cls_e              cls_cl,
  input  logic              pair_mode,
  output logic [MASK_W-1:0] mask
);
  cls_e              pair_cls [2];
  logic [PAIR_W-1:0] pair_pick [2];

  assign pair_cls[0] = cls_ab;
  assign pair_cls[1] = cls_cd;

  for (genvar g = 0; g < 2; g++) begin : g_pick
    pdh_pair_pick u_pick (
      .cls  (pair_cls[g]),
      .pick (pair_pick[g])
    );
  end

  logic [MASK_W-1:0] tree_mask;
  logic [MASK_W-1:0] pair_mask;
  logic              both_sides;

  always_comb begin
    both_sides = (|pair_pick[0]) && (|pair_pick[1]);
    unique case (cls_sum)
      CLS_POS: tree_mask = {2'b00, pair_pick[0]};
      CLS_NEG: tree_mask = {pair_pick[1], 2'b00};
      default: tree_mask = both_sides ? {pair_pick[1], pair_pick[0]} : '0;
    endcase
  end

  always_comb begin
    pair_mask[1:0] = (cls_al == CLS_POS) ? pair_pick[0] : 2'b00;
    pair_mask[3:2] = (cls_cl == CLS_POS) ? pair_pick[1] : 2'b00;
  end

  assign mask = pair_mode ? pair_mask : tree_mask;
endmodule

// File: rtl/pdh_hit_decoder.sv
module pdh_hit_decoder
  import pdh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              pair_mode,
  input  logic [DATA_W-1:0] sum_diff,
  input  logic [DATA_W-1:0] ab_diff,
  input  logic [DATA_W-1:0] cd_diff,
  input  logic [DATA_W-1:0] a_level,
  input  logic [DATA_W-1:0] c_level,
  input  logic [DATA_W-2:0] thresh,
  output logic              out_valid,
  output logic [3:0]        out_mask
);
  logic rst_sync_n;

  pdh_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [DATA_W-1:0] cls_in [NUM_CLS];
  cls_e              cls_out [NUM_CLS];

  assign cls_in[IDX_SUM] = sum_diff;
  assign cls_in[IDX_AB]  = ab_diff;
  assign cls_in[IDX_CD]  = cd_diff;
  assign cls_in[IDX_AL]  = a_level;
  assign cls_in[IDX_CL]  = c_level;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    pdh_classify #(.DATA_W(DATA_W)) u_cls (
      .value  (cls_in[g]),
      .thresh (thresh),
      .cls    (cls_out[g])
    );
  end

  logic [MASK_W-1:0] dec_mask;

  pdh_resolve u_res (
    .cls_sum   (cls_out[IDX_SUM]),
    .cls_ab    (cls_out[IDX_AB]),
    .cls_cd    (cls_out[IDX_CD]),
    .cls_al    (cls_out[IDX_AL]),
    .cls_cl    (cls_out[IDX_CL]),
    .pair_mode (pair_mode),
    .mask      (dec_mask)
  );

  logic              valid_d, valid_q;
  logic [MASK_W-1:0] mask_d, mask_q;
  logic              mask_en;

  always_comb begin
    mask_en = in_valid;
    valid_d = in_valid;
    mask_d  = mask_en ? dec_mask : mask_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
    end
  end

  assign out_valid = valid_q;
  assign out_mask  = mask_q;
endmodule

// File: rtl/pdh_hit_decoder_chk.sv
module pdh_hit_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              pair_mode,
  input logic [DATA_W-1:0] sum_diff,
  input logic [DATA_W-1:0] ab_diff,
  input logic [DATA_W-1:0] a_level,
  input logic [DATA_W-2:0] thresh,
  input logic              out_valid,
  input logic [3:0]        out_mask
);
  logic signed [DATA_W:0] s_ext, ab_ext, al_ext, th_ext;
  assign s_ext  = $signed({sum_diff[DATA_W-1], sum_diff});
  assign ab_ext = $signed({ab_diff[DATA_W-1], ab_diff});
  assign al_ext = $signed({a_level[DATA_W-1], a_level});
  assign th_ext = $signed({2'b00, thresh});

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_mask));

  p_tree_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_mode && s_ext > th_ext) |=> out_mask[3:2] == 2'b00);

  p_tree_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_mode && s_ext < -th_ext) |=> out_mask[1:0] == 2'b00);

  p_equal_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ab_ext <= th_ext && ab_ext >= -th_ext) |=> out_mask[1:0] == 2'b00);

  p_pair_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_mode && al_ext <= th_ext) |=> out_mask[1:0] == 2'b00);

  p_one_per_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_mask[0] && out_mask[1]) && !(out_mask[2] && out_mask[3]));
endmodule

bind pdh_hit_decoder pdh_hit_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .pair_mode (pair_mode),
  .sum_diff  (sum_diff),
  .ab_diff   (ab_diff),
  .a_level   (a_level),
  .thresh    (thresh),
  .out_valid (out_valid),
  .out_mask  (out_mask)
);

// File: tb/pdh_hit_decoder_tb.sv
module pdh_hit_decoder_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              pair_mode = 1'b0;
  logic [DATA_W-1:0] sum_diff = '0, ab_diff = '0, cd_diff = '0, a_level = '0, c_level = '0;
  logic [DATA_W-2:0] thresh = '0;
  logic              out_valid;
  logic [3:0]        out_mask;

  int    checks = 0;
  int    failures = 0;
  bit    model_on = 1'b0;
  bit    done = 1'b0;
  bit    exp_valid = 1'b0;
  logic [3:0] exp_mask = 4'b0000;
  string exp_tag = "R2";

  always #(CLK_P/2) clk = ~clk;

  pdh_hit_decoder #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pair_mode(pair_mode),
    .sum_diff(sum_diff), .ab_diff(ab_diff), .cd_diff(cd_diff),
    .a_level(a_level), .c_level(c_level), .thresh(thresh),
    .out_valid(out_valid), .out_mask(out_mask)
  );

  function automatic int sgn_cls(int x, int th);
    if (x > th) return 1;
    if (x < -th) return -1;
    return 0;
  endfunction

  // two-bit pick within a pair: low pixel on positive, high pixel on negative
  function automatic int pick2(int c);
    if (c == 1) return 1;
    if (c == -1) return 2;
    return 0;
  endfunction

  function automatic int to_int(logic [DATA_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [3:0] ref_mask(bit pm, int s, int ab, int cd, int al, int cl, int th);
    int pab = pick2(sgn_cls(ab, th));
    int pcd = pick2(sgn_cls(cd, th));
    int lo = 0, hi = 0;
    if (pm) begin
      lo = (al > th) ? pab : 0;
      hi = (cl > th) ? pcd : 0;
    end else begin
      case (sgn_cls(s, th))
        1:  lo = pab;
        -1: hi = pcd;
        default: if (pab != 0 && pcd != 0) begin lo = pab; hi = pcd; end
      endcase
    end
    return 4'(hi * 4 + lo);
  endfunction

  // cycle reference model
  always @(posedge clk) begin
    if (model_on) begin
      exp_valid = in_valid;
      if (in_valid) begin
        exp_mask = ref_mask(pair_mode, to_int(sum_diff), to_int(ab_diff), to_int(cd_diff),
                            to_int(a_level), to_int(c_level), int'(thresh));
        if (pair_mode) exp_tag = "R9";
        else case (sgn_cls(to_int(sum_diff), int'(thresh)))
          1: exp_tag = "R5";
          -1: exp_tag = "R6";
          default: exp_tag = "R7";
        endcase
      end else exp_tag = "R3";
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      checks++;
      if (out_valid !== exp_valid) begin
        failures++;
        $display("FAIL R2 out_valid actual %b expected %b", out_valid, exp_valid);
      end
      checks++;
      if (out_mask !== exp_mask) begin
        failures++;
        $display("FAIL %s out_mask actual %b expected %b", exp_tag, out_mask, exp_mask);
      end
    end
  end

  task automatic drive(bit pm, int s, int ab, int cd, int al, int cl, int th, bit v);
    @(negedge clk);
    pair_mode = pm;
    sum_diff = s[DATA_W-1:0];
    ab_diff  = ab[DATA_W-1:0];
    cd_diff  = cd[DATA_W-1:0];
    a_level  = al[DATA_W-1:0];
    c_level  = cl[DATA_W-1:0];
    thresh   = th[DATA_W-2:0];
    in_valid = v;
  endtask

  task automatic vec(bit pm, int s, int ab, int cd, int al, int cl, int th,
                     logic [3:0] hand, string tag);
    drive(pm, s, ab, cd, al, cl, th, 1'b1);
    @(negedge clk);
    checks++;
    if (out_mask !== hand || out_valid !== 1'b1) begin
      failures++;
      $display("FAIL %s directed mask actual %b/%b expected %b/1", tag, out_mask, out_valid, hand);
    end
  endtask

  task automatic chk_reset(string when);
    checks++;
    if (out_valid !== 1'b0 || out_mask !== 4'b0000) begin
      failures++;
      $display("FAIL R1 %s actual %b/%b expected 0/0000", when, out_valid, out_mask);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset("during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_reset("after release");
    model_on = 1'b1;

    // R4 band edges, R5 positive imbalance
    vec(0, 4, 4, 0, 0, 0, 3, 4'b0001, "R5");
    vec(0, 4, -4, 9, 0, 0, 3, 4'b0010, "R5");
    vec(0, 3, 4, -4, 0, 0, 3, 4'b1001, "R4");
    vec(0, -3, -4, 4, 0, 0, 3, 4'b0110, "R4");
    // R8 equal pair
    vec(0, 4, 3, 0, 0, 0, 3, 4'b0000, "R8");
    vec(0, 4, -3, 0, 0, 0, 3, 4'b0000, "R8");
    vec(0, -4, 9, 0, 0, 0, 3, 4'b0000, "R8");
    // R6 negative imbalance
    vec(0, -10, 9, 6, 0, 0, 3, 4'b0100, "R6");
    vec(0, -4, 0, -4, 0, 0, 3, 4'b1000, "R6");
    // R7 zero imbalance
    vec(0, 0, -5, 5, 0, 0, 3, 4'b0110, "R7");
    vec(0, 0, 5, 0, 0, 0, 3, 4'b0000, "R7");
    vec(0, 0, 0, -5, 0, 0, 3, 4'b0000, "R7");
    // R4 extremes
    vec(0, -128, 0, 127, 0, 0, 127, 4'b0000, "R4");
    vec(0, -128, 0, -128, 0, 0, 127, 4'b1000, "R4");
    vec(0, 127, 127, 0, 0, 0, 127, 4'b0000, "R4");
    // R9 pair mode, imbalance ignored
    vec(1, -100, 4, 5, 5, 3, 3, 4'b0001, "R9");
    vec(1, -100, -7, -4, 4, 10, 3, 4'b1010, "R9");
    vec(1, 100, 9, 9, 3, -20, 3, 4'b0000, "R9");
    // R10 same differences, tree mode
    vec(0, -100, -7, -4, 4, 10, 3, 4'b1000, "R10");
    // R3 hold while idle
    drive(0, 50, 50, 50, 0, 0, 0, 1'b0);
    drive(1, -50, -50, -50, 90, 90, 0, 1'b0);
    @(negedge clk);
    checks++;
    if (out_mask !== 4'b1000 || out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R3 hold actual %b/%b expected 1000/0", out_mask, out_valid);
    end

    // random run near the band edges
    for (int i = 0; i < 4000; i++) begin
      int th = ($urandom_range(0, 15) == 0) ? 127 : int'($urandom_range(0, 6));
      drive(1'($urandom_range(0, 1)),
            int'($urandom_range(0, 24)) - 12, int'($urandom_range(0, 20)) - 10,
            int'($urandom_range(0, 20)) - 10, int'($urandom_range(0, 20)) - 10,
            int'($urandom_range(0, 20)) - 10, th, ($urandom_range(0, 3) != 0));
    end
    drive(0, 0, 0, 0, 0, 0, 0, 1'b0);
    repeat (2) @(negedge clk);

    // R1 re-entry into reset
    rst_n = 1'b0;
    #1;
    model_on = 1'b0;
    chk_reset("asserted again");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule